// File: doc/BRIEF.md
# Conditional Flag-Setting Data-Processing ALU

This block is the integer arithmetic/logic stage for register-to-register data-processing operations. Each cycle it takes a 4-bit operation code, a first operand, a second operand that has already been through the shifter along with the carry that shifter produced, the current four condition flags, a set-flags request and a 4-bit condition field. One clock later it presents the operation result, a register write enable and the next value of the flag set.

Before anything happens, the condition field is tested against the incoming flags. If the test fails, the operation is cancelled: no register write and no flag change. Four of the sixteen operations are compares. They produce flags only and never write a register. The carry flag comes from the adder for arithmetic operations and from the shifter for logical ones. Logical operations leave the overflow flag untouched.

Top module: `dp_alu`

## Requirements
- R1: Arithmetic opcodes compute, modulo 2^WIDTH: ADD (4) A+B, ADC (5) A+B+C, SUB (2) A-B, SBC (6) A-B+C-1, RSB (3) B-A, RSC (7) B-A+C-1. Here C is the incoming carry flag.
- R2: Logical opcodes compute: AND (0) A&B, EOR (1) A^B, ORR (12) A|B, BIC (14) A&~B, MOV (13) B and MVN (15) ~B. MOV and MVN do not depend on A.
- R3: The compare opcodes TST (8), TEQ (9), CMP (10) and CMN (11) never assert the write enable. When their condition passes they update the flags whatever the set-flags input is, as AND, XOR, subtract and add respectively.
- R4: A non-compare operation with the set-flags input at 0 leaves flags_o equal to flags_i.
- R5: When flags are updated, N (flags bit 3) is the result MSB and Z (flags bit 2) is 1 exactly when the result is zero.
- R6: For arithmetic operations C (flags bit 1) is the adder carry-out. For subtractions this is the inverted borrow: 1 when no borrow occurs.
- R7: For arithmetic operations V (flags bit 0) is 1 exactly when the signed result does not fit in WIDTH bits.
- R8: For logical operations and TST/TEQ, C takes the shifter carry input and V keeps its incoming value.
- R9: Condition codes 0 to 14 are EQ Z, NE !Z, CS C, CC !C, MI N, PL !N, VS V, VC !V, HI C&!Z, LS !C|Z, GE N==V, LT N!=V, GT !Z&(N==V), LE Z|(N!=V), AL always. A failed condition suppresses both the write and the flag update.
- R10: Condition code 15 never executes: the write enable is 0 and flags_o equals flags_i.
- R11: Outputs are registered with one cycle of latency. While reset is asserted, result_o, wr_en_o and flags_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| cond_i | input | 4 | Condition field |
| s_i | input | 1 | Set-flags request |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Shifted second operand |
| sh_carry_i | input | 1 | Carry out of the shifter |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| result_o | output | WIDTH | Operation result |
| wr_en_o | output | 1 | Destination register write enable |
| flags_o | output | 4 | Next flags {N,Z,C,V} |

## Verification
At a 4-bit width the bench sweeps every opcode against every operand pair and both shifter-carry values. This catches three kinds of error: a subtraction carry reported as a raw borrow (C inverted on every subtract), a reverse subtract with its operands swapped back, and a carry-in dropped from ADC, SBC or RSC (results off by one only when C is set). Overflow is compared with a signed reference. That exposes a V taken from the carry-out, or a logical operation that clears V instead of keeping it. A separate pass with set-flags at 0 checks that compares still set flags while other operations leave them alone. A sweep of all condition codes against all sixteen flag patterns exposes any swapped encoding, an inverted GE/LT test, or a code 15 that executes as always.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } op_e;

  typedef enum logic [3:0] {
    CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
    CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
    CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
    CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
  } cond_e;

  typedef enum logic [1:0] {CIN_ZERO, CIN_ONE, CIN_FLAG} cin_e;

  typedef struct packed {
    logic arith;
    logic cmp;
    logic swap;
    logic inv;
    cin_e cin;
  } dec_t;

  localparam int FL_N = 3;
  localparam int FL_Z = 2;
  localparam int FL_C = 1;
  localparam int FL_V = 0;
endpackage

// File: rtl/dp_alu_cond.sv
module dp_alu_cond
  import dp_alu_pkg::*;
(
  input  logic [3:0] cond_i,
  input  logic [3:0] flags_i,
  output logic       pass_o
);
  logic n, z, c, v;
  assign n = flags_i[FL_N];
  assign z = flags_i[FL_Z];
  assign c = flags_i[FL_C];
  assign v = flags_i[FL_V];

  always_comb begin
    unique case (cond_e'(cond_i))
      CC_EQ:   pass_o = z;
      CC_NE:   pass_o = ~z;
      CC_CS:   pass_o = c;
      CC_CC:   pass_o = ~c;
      CC_MI:   pass_o = n;
      CC_PL:   pass_o = ~n;
      CC_VS:   pass_o = v;
      CC_VC:   pass_o = ~v;
      CC_HI:   pass_o = c & ~z;
      CC_LS:   pass_o = ~c | z;
      CC_GE:   pass_o = (n == v);
      CC_LT:   pass_o = (n != v);
      CC_GT:   pass_o = ~z & (n == v);
      CC_LE:   pass_o = z | (n != v);
      CC_AL:   pass_o = 1'b1;
      default: pass_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dp_alu_decode.sv
module dp_alu_decode
  import dp_alu_pkg::*;
(
  input  logic [3:0] op_i,
  output dec_t       dec_o
);
  always_comb begin
    dec_o = '{arith: 1'b0, cmp: 1'b0, swap: 1'b0, inv: 1'b0, cin: CIN_ZERO};
    unique case (op_e'(op_i))
      OP_ADD: dec_o.arith = 1'b1;
      OP_ADC: begin dec_o.arith = 1'b1; dec_o.cin = CIN_FLAG; end
      OP_SUB: begin dec_o.arith = 1'b1; dec_o.inv = 1'b1; dec_o.cin = CIN_ONE; end
      OP_SBC: begin dec_o.arith = 1'b1; dec_o.inv = 1'b1; dec_o.cin = CIN_FLAG; end
      OP_RSB: begin
        dec_o.arith = 1'b1; dec_o.swap = 1'b1; dec_o.inv = 1'b1; dec_o.cin = CIN_ONE;
      end
      OP_RSC: begin
        dec_o.arith = 1'b1; dec_o.swap = 1'b1; dec_o.inv = 1'b1; dec_o.cin = CIN_FLAG;
      end
      OP_CMP: begin
        dec_o.arith = 1'b1; dec_o.cmp = 1'b1; dec_o.inv = 1'b1; dec_o.cin = CIN_ONE;
      end
      OP_CMN: begin dec_o.arith = 1'b1; dec_o.cmp = 1'b1; end
      OP_TST, OP_TEQ: dec_o.cmp = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/dp_alu_adder.sv
module dp_alu_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  logic [WIDTH:0] cy;
  assign cy[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sum_o[i]  = x_i[i] ^ y_i[i] ^ cy[i];
    assign cy[i+1]   = (x_i[i] & y_i[i]) | (cy[i] & (x_i[i] ^ y_i[i]));
  end

  assign cout_o = cy[WIDTH];
  // signed overflow: carry into MSB differs from carry out
  assign ovf_o  = cy[WIDTH] ^ cy[WIDTH-1];
endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    unique case (op_e'(op_i))
      OP_AND, OP_TST: res_o = a_i & b_i;
      OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
      OP_ORR:         res_o = a_i | b_i;
      OP_BIC:         res_o = a_i & ~b_i;
      OP_MOV:         res_o = b_i;
      OP_MVN:         res_o = ~b_i;
      default:        res_o = '0;
    endcase
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       op_i,
  input  logic [3:0]       cond_i,
  input  logic             s_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sh_carry_i,
  input  logic [3:0]       flags_i,
  output logic [WIDTH-1:0] result_o,
  output logic             wr_en_o,
  output logic [3:0]       flags_o
);
  localparam int MSB = WIDTH - 1;

  dec_t             dec;
  logic             pass;
  logic [WIDTH-1:0] add_x, add_y, sum, log_res, res;
  logic             add_cin, cout, ovf;
  logic             we_d, upd;
  logic [3:0]       flags_d;

  dp_alu_decode u_dec (.op_i(op_i), .dec_o(dec));

  dp_alu_cond u_cond (.cond_i(cond_i), .flags_i(flags_i), .pass_o(pass));

  always_comb begin
    add_x = dec.swap ? b_i : a_i;
    add_y = dec.swap ? a_i : b_i;
    if (dec.inv) add_y = ~add_y;
    unique case (dec.cin)
      CIN_ONE:  add_cin = 1'b1;
      CIN_FLAG: add_cin = flags_i[FL_C];
      default:  add_cin = 1'b0;
    endcase
  end

  dp_alu_adder #(.WIDTH(WIDTH)) u_add (
    .x_i(add_x), .y_i(add_y), .cin_i(add_cin),
    .sum_o(sum), .cout_o(cout), .ovf_o(ovf)
  );

  dp_alu_logic #(.WIDTH(WIDTH)) u_log (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .res_o(log_res)
  );

  always_comb begin
    res  = dec.arith ? sum : log_res;
    we_d = pass & ~dec.cmp;
    upd  = pass & (s_i | dec.cmp);
    if (upd) begin
      flags_d[FL_N] = res[MSB];
      flags_d[FL_Z] = ~|res;
      flags_d[FL_C] = dec.arith ? cout : sh_carry_i;
      flags_d[FL_V] = dec.arith ? ovf  : flags_i[FL_V];
    end else begin
      flags_d = flags_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      wr_en_o  <= 1'b0;
      flags_o  <= '0;
    end else begin
      result_o <= res;
      wr_en_o  <= we_d;
      flags_o  <= flags_d;
    end
  end
endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       op_i,
  input logic [3:0]       cond_i,
  input logic             s_i,
  input logic [WIDTH-1:0] b_i,
  input logic [3:0]       flags_i,
  input logic [WIDTH-1:0] result_o,
  input logic             wr_en_o,
  input logic [3:0]       flags_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  logic is_cmp, is_logic;
  assign is_cmp   = (op_i[3:2] == 2'b10);
  assign is_logic = (op_i == 4'd0) || (op_i == 4'd1) || (op_i >= 4'd12) ||
                    (op_i == 4'd8) || (op_i == 4'd9);

  assert_cmp_no_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(is_cmp) |-> !wr_en_o);

  assert_s0_keeps_flags_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(!s_i && !is_cmp) |-> flags_o == $past(flags_i));

  assert_nz_match_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && wr_en_o && $past(s_i) |->
      (flags_o[2] == (result_o == '0)) && (flags_o[3] == result_o[WIDTH-1]));

  assert_logic_keeps_v_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(is_logic) |-> flags_o[0] == $past(flags_i[0]));

  assert_never_cond_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(cond_i == 4'hF) |-> !wr_en_o && flags_o == $past(flags_i));

  assert_mov_passes_b_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(op_i == 4'd13 && cond_i == 4'd14) |->
      wr_en_o && result_o == $past(b_i));
endmodule

bind dp_alu dp_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .cond_i(cond_i), .s_i(s_i),
  .b_i(b_i), .flags_i(flags_i), .result_o(result_o), .wr_en_o(wr_en_o),
  .flags_o(flags_o)
);

// File: tb/dp_alu_tb.sv
module dp_alu_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 4;
  localparam int MASK = (1 << W) - 1;
  localparam int HALF = 1 << (W - 1);

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [3:0]   op_i = '0, cond_i = 4'd14, flags_i = '0;
  logic         s_i = 1'b0, sh_carry_i = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [W-1:0] result_o;
  logic         wr_en_o;
  logic [3:0]   flags_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dp_alu #(.WIDTH(W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .cond_i(cond_i), .s_i(s_i),
    .a_i(a_i), .b_i(b_i), .sh_carry_i(sh_carry_i), .flags_i(flags_i),
    .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
  );

  function automatic bit cond_ok(input int cc, input logic [3:0] f);
    bit n = f[3], z = f[2], c = f[1], v = f[0];
    case (cc)
      0: return z;          1: return !z;
      2: return c;          3: return !c;
      4: return n;          5: return !n;
      6: return v;          7: return !v;
      8: return c && !z;    9: return !c || z;
      10: return n == v;    11: return n != v;
      12: return !z && n == v;
      13: return z || n != v;
      14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int sgn(input int x);
    return (x >= HALF) ? x - (1 << W) : x;
  endfunction

  // reference model: arithmetic on integers
  task automatic model(input int op, input int a, input int b, input bit sc,
                       input logic [3:0] f, input bit s, input int cc,
                       output int e_res, output bit e_we, output logic [3:0] e_fl);
    int r, sr, cf;
    bit arith, sub, cmp, c, v, pass;
    cf = f[1];
    arith = 1; sub = 0; r = 0; sr = 0;
    case (op)
      4, 11: begin r = a + b;          sr = sgn(a) + sgn(b); end
      5:     begin r = a + b + cf;     sr = sgn(a) + sgn(b) + cf; end
      2, 10: begin r = a - b;          sr = sgn(a) - sgn(b); sub = 1; end
      6:     begin r = a - b + cf - 1; sr = sgn(a) - sgn(b) + cf - 1; sub = 1; end
      3:     begin r = b - a;          sr = sgn(b) - sgn(a); sub = 1; end
      7:     begin r = b - a + cf - 1; sr = sgn(b) - sgn(a) + cf - 1; sub = 1; end
      default: arith = 0;
    endcase
    if (!arith) begin
      case (op)
        0, 8:  r = a & b;
        1, 9:  r = a ^ b;
        12:    r = a | b;
        13:    r = b;
        14:    r = a & (~b & MASK);
        default: r = ~b & MASK;
      endcase
      c = sc; v = f[0];
    end else begin
      c = sub ? (r >= 0) : (r > MASK);
      v = (sr > HALF - 1) || (sr < -HALF);
    end
    e_res = r & MASK;
    cmp  = (op >= 8 && op <= 11);
    pass = cond_ok(cc, f);
    e_we = pass && !cmp;
    if (pass && (s || cmp)) e_fl = {e_res[W-1], e_res == 0, c, v};
    else                    e_fl = f;
  endtask

  task automatic run(input int op, input int a, input int b, input bit sc,
                     input logic [3:0] f, input bit s, input int cc, input string tag);
    int er; bit ew; logic [3:0] ef;
    op_i = op[3:0]; a_i = a[W-1:0]; b_i = b[W-1:0]; sh_carry_i = sc;
    flags_i = f; s_i = s; cond_i = cc[3:0];
    model(op, a, b, sc, f, s, cc, er, ew, ef);
    @(negedge clk_i);
    n_chk++;
    if (wr_en_o !== ew || flags_o !== ef || (ew && result_o !== er[W-1:0])) begin
      n_bad++;
      if (n_bad <= 20)
        $display("FAIL %s op=%0d cc=%0d a=%0d b=%0d f=%b s=%0b: got res=%0d we=%0b fl=%b exp res=%0d we=%0b fl=%b",
                 tag, op, cc, a, b, f, s, result_o, wr_en_o, flags_o, er, ew, ef);
    end
  endtask

  function automatic string tag_of(input int op);
    if (op >= 8 && op <= 11) return "R3 R5";
    if (op >= 2 && op <= 7)  return "R1 R5 R6 R7";
    return "R2 R5 R8";
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    n_chk++;  // R11 reset state
    if (result_o !== '0 || wr_en_o !== 1'b0 || flags_o !== 4'b0) begin
      n_bad++;
      $display("FAIL R11 reset: got res=%0d we=%0b fl=%b exp 0 0 0000", result_o, wr_en_o, flags_o);
    end
    rst_ni = 1'b1;

    // R1 R2 R3 R5 R6 R7 R8: every opcode, operand pair and shifter carry
    for (int op = 0; op < 16; op++)
      for (int a = 0; a <= MASK; a++)
        for (int b = 0; b <= MASK; b++)
          for (int sc = 0; sc < 2; sc++)
            run(op, a, b, sc[0], 4'((a + b + op + sc) & 15), 1'b1, 14, tag_of(op));

    // R4 and R3: set-flags off
    for (int op = 0; op < 16; op++)
      for (int a = 0; a <= MASK; a++)
        for (int b = 0; b <= MASK; b += 5)
          run(op, a, b, 1'b1, 4'((a * 3 + b) & 15), 1'b0, 14,
              (op >= 8 && op <= 11) ? "R3" : "R4");

    // R9 R10: every condition against every flag pattern
    for (int cc = 0; cc < 16; cc++)
      for (int f = 0; f < 16; f++) begin
        run(4, 3, 5, 1'b0, f[3:0], 1'b1, cc, cc == 15 ? "R10" : "R9");
        run(10, 7, 2, 1'b0, f[3:0], 1'b0, cc, cc == 15 ? "R10" : "R9");
        run(13, 9, 6, 1'b1, f[3:0], 1'b1, cc, cc == 15 ? "R10" : "R9");
      end

    // R11: back-to-back vectors with one-cycle latency, then reset clears
    run(4, 7, 1, 1'b0, 4'b0000, 1'b1, 14, "R11");
    run(2, 0, 1, 1'b0, 4'b0000, 1'b1, 14, "R11");
    rst_ni = 1'b0;
    #1;
    n_chk++;
    if (result_o !== '0 || wr_en_o !== 1'b0 || flags_o !== 4'b0) begin
      n_bad++;
      $display("FAIL R11 async reset: got res=%0d we=%0b fl=%b exp 0 0 0000", result_o, wr_en_o, flags_o);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule